// File: doc/BRIEF.md
# Prime-Modulus Memory Bank Interleaver

This block takes a stream of physical byte addresses and decides which of 31 memory banks serves each one, and at which word position inside that bank the data lives. Because 31 is prime, a run of accesses with a fixed stride visits every bank once per 31 accesses. The only exception is a stride that is itself a multiple of 31 units. Power-of-two strides, which would pile onto one bank under a low-order-bit interleave, are spread evenly.

Each request carries an address and a one-bit mode. In quadword mode the interleave unit is 8 bytes, so single-word traffic keeps full throughput. In line mode the unit is a 64-byte cache line. The bank is the unit index modulo 31, and the in-bank offset is the unit index divided by 31. Both are computed without a divider. The residue comes from summing 5-bit slices of the index, since 32 leaves a remainder of 1 modulo 31, and then folding the sum. The quotient comes from an exact division: the residue is subtracted, and the result is multiplied by the inverse of 31 modulo a power of two.

The datapath is a three-stage pipeline with valid/ready handshakes on both sides. When the consumer stalls, the whole pipeline holds.

Top module: `prime_bank_map`

## Requirements
- R1: With `req_line` = 0 (quadword mode), the unit index is `req_addr >> 3` and `rsp_bank` equals the unit index modulo 31.
- R2: With `req_line` = 1 (line mode), the unit index is `req_addr >> 6`, so address bits 5..0 have no effect, and `rsp_bank` equals that index modulo 31.
- R3: `rsp_offset` equals the unit index divided by 31, rounded down, in both modes.
- R4: A unit index that is a multiple of 31 gives bank 0. This includes indices whose slice sum folds to exactly 31, such as 31, 62 and 961.
- R5: A request accepted at a clock edge, with `rsp_ready` high at that edge and at the next two, shows up on `rsp_valid` after the third edge.
- R6: Responses leave in the order the requests were accepted, with none lost or duplicated under any `rsp_ready` pattern. At most 3 requests are in flight.
- R7: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid`, `rsp_bank` and `rsp_offset` hold their values.
- R8: `req_ready` is low while the output is stalled (`rsp_valid` high, `rsp_ready` low) and high otherwise.
- R9: After reset `rsp_valid` is low and `req_ready` is high, and no response appears without a prior accepted request.
- R10: For 31 consecutive quadword accesses with a stride of s units, every bank is hit exactly once when s is not a multiple of 31. When s is a multiple of 31, all 31 accesses hit a single bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request this cycle |
| req_addr | input | ADDR_W (40) | Physical byte address |
| req_line | input | 1 | 0 = 8-byte quadword unit, 1 = 64-byte line unit |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Consumer takes the result this cycle |
| rsp_bank | output | CHUNK_W (5) | Bank index, 0..30 |
| rsp_offset | output | OFF_W (33) | Unit position within the bank |

## Verification
The hardest case to reach from the ports is an index whose slice sum lands exactly on 31 or on a multiple of 32. Only these exercise the final fold and the map from 31 to 0. Random addresses almost never produce them, so the bench drives directed indices such as 31, 62, 961 and all-ones addresses in both modes. It then sweeps every stride from 1 to 64, checking bank coverage over each 31-access window, which includes strides 31 and 62. Ordering under stalls is covered by a phase with random consumer backpressure. A separate phase holds `rsp_ready` low long enough to fill the pipeline.

// File: rtl/pbm_pkg.sv
package pbm_pkg;

   typedef enum logic {
      MODE_WORD = 1'b0,
      MODE_LINE = 1'b1
   } pbm_mode_e;

   // Inverse of an odd value modulo 2^64 by Newton iteration;
   // each step doubles the number of correct low bits (3 -> 192).
   function automatic longint unsigned pbm_inv_pow2(input longint unsigned m);
      longint unsigned y;
      y = m;
      for (int i = 0; i < 6; i++) begin
         y = y * (64'd2 - m * y);
      end
      return y;
   endfunction

endpackage

// File: rtl/pbm_unit_sel.sv
module pbm_unit_sel
   import pbm_pkg::*;
#(
   parameter int ADDR_W     = 40,
   parameter int QW_SHIFT   = 3,
   parameter int LINE_SHIFT = 6,
   localparam int UNIT_W    = ADDR_W - QW_SHIFT
) (
   input  logic [ADDR_W-1:0] addr,
   input  pbm_mode_e         mode,
   output logic [UNIT_W-1:0] unit
);

   always_comb begin
      unique case (mode)
         MODE_LINE: unit = UNIT_W'(addr >> LINE_SHIFT);
         default:   unit = UNIT_W'(addr >> QW_SHIFT);
      endcase
   end

endmodule

// File: rtl/pbm_chunk_sum.sv
module pbm_chunk_sum #(
   parameter int UNIT_W  = 37,
   parameter int CHUNK_W = 5,
   localparam int NCHUNK = (UNIT_W + CHUNK_W - 1) / CHUNK_W,
   localparam int PAD_W  = NCHUNK * CHUNK_W - UNIT_W,
   localparam int SUM_W  = CHUNK_W + $clog2(NCHUNK)
) (
   input  logic [UNIT_W-1:0] unit,
   output logic [SUM_W-1:0]  sum
);

   logic [NCHUNK*CHUNK_W-1:0] padded;
   logic [CHUNK_W-1:0]        slice [NCHUNK];

   generate
      if (PAD_W > 0) begin : g_pad
         assign padded = {{PAD_W{1'b0}}, unit};
      end else begin : g_nopad
         assign padded = unit;
      end
      for (genvar g = 0; g < NCHUNK; g++) begin : g_slice
         assign slice[g] = padded[g*CHUNK_W +: CHUNK_W];
      end
   endgenerate

   always_comb begin
      sum = '0;
      for (int i = 0; i < NCHUNK; i++) begin
         sum = sum + SUM_W'(slice[i]);
      end
   end

endmodule

// File: rtl/pbm_fold.sv
module pbm_fold #(
   parameter int CHUNK_W = 5,
   parameter int SUM_W   = 8,
   localparam int MODULUS = (1 << CHUNK_W) - 1
) (
   input  logic [SUM_W-1:0]   sum,
   output logic [CHUNK_W-1:0] residue
);

   logic [SUM_W-1:0]   f1, f2;
   logic [CHUNK_W-1:0] f3;

   // With SUM_W <= 2*CHUNK_W: f1 < 2^(C+1), f2 <= 2^C, f3 <= 2^C - 1.
   always_comb begin
      f1 = SUM_W'(sum[CHUNK_W-1:0]) + (sum >> CHUNK_W);
      f2 = SUM_W'(f1[CHUNK_W-1:0]) + (f1 >> CHUNK_W);
      f3 = CHUNK_W'(SUM_W'(f2[CHUNK_W-1:0]) + (f2 >> CHUNK_W));
      residue = (f3 == CHUNK_W'(MODULUS)) ? '0 : f3;
   end

endmodule

// File: rtl/pbm_exact_div.sv
module pbm_exact_div
   import pbm_pkg::*;
#(
   parameter int W       = 33,
   parameter int MODULUS = 31
) (
   input  logic [W-1:0] dividend,
   output logic [W-1:0] quotient
);

   localparam logic [W-1:0] INV = W'(pbm_inv_pow2(64'(MODULUS)));

   // dividend is an exact multiple of MODULUS, so the product
   // modulo 2^W is the true quotient whenever it fits in W bits.
   assign quotient = dividend * INV;

endmodule

// File: rtl/prime_bank_map.sv
module prime_bank_map
   import pbm_pkg::*;
#(
   parameter int ADDR_W     = 40,
   parameter int CHUNK_W    = 5,
   parameter int QW_SHIFT   = 3,
   parameter int LINE_SHIFT = 6,
   localparam int MODULUS   = (1 << CHUNK_W) - 1,
   localparam int UNIT_W    = ADDR_W - QW_SHIFT,
   localparam int NCHUNK    = (UNIT_W + CHUNK_W - 1) / CHUNK_W,
   localparam int SUM_W     = CHUNK_W + $clog2(NCHUNK),
   localparam int OFF_W     = UNIT_W - CHUNK_W + 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   output logic               req_ready,
   input  logic [ADDR_W-1:0]  req_addr,
   input  logic               req_line,
   output logic               rsp_valid,
   input  logic               rsp_ready,
   output logic [CHUNK_W-1:0] rsp_bank,
   output logic [OFF_W-1:0]   rsp_offset
);

   generate
      if (!(CHUNK_W == 2 || CHUNK_W == 3 || CHUNK_W == 5 || CHUNK_W == 7)) begin : g_bad_prime
         $error("CHUNK_W must make 2^CHUNK_W-1 a Mersenne prime");
      end
      if (LINE_SHIFT <= QW_SHIFT) begin : g_bad_shift
         $error("LINE_SHIFT must exceed QW_SHIFT");
      end
      if (UNIT_W > 64 || UNIT_W <= CHUNK_W) begin : g_bad_width
         $error("unit index width out of range");
      end
      if (SUM_W > 2 * CHUNK_W) begin : g_bad_sum
         $error("slice sum too wide for three folds");
      end
   endgenerate

   logic [UNIT_W-1:0]  unit;
   logic [SUM_W-1:0]   sum;
   logic [CHUNK_W-1:0] residue;
   logic [OFF_W-1:0]   quotient;
   logic               adv;

   logic               s1_v, s2_v;
   logic [SUM_W-1:0]   s1_sum;
   logic [OFF_W-1:0]   s1_unit_lo, s2_diff;
   logic [CHUNK_W-1:0] s2_bank;

   pbm_unit_sel #(
      .ADDR_W(ADDR_W), .QW_SHIFT(QW_SHIFT), .LINE_SHIFT(LINE_SHIFT)
   ) u_unit_sel (
      .addr(req_addr), .mode(pbm_mode_e'(req_line)), .unit(unit)
   );

   pbm_chunk_sum #(.UNIT_W(UNIT_W), .CHUNK_W(CHUNK_W)) u_chunk_sum (
      .unit(unit), .sum(sum)
   );

   pbm_fold #(.CHUNK_W(CHUNK_W), .SUM_W(SUM_W)) u_fold (
      .sum(s1_sum), .residue(residue)
   );

   pbm_exact_div #(.W(OFF_W), .MODULUS(MODULUS)) u_exact_div (
      .dividend(s2_diff), .quotient(quotient)
   );

   // Whole pipeline advances together unless the output is held.
   assign adv       = rsp_ready || !rsp_valid;
   assign req_ready = adv;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s1_v      <= 1'b0;
         s2_v      <= 1'b0;
         rsp_valid <= 1'b0;
      end else if (adv) begin
         s1_v      <= req_valid;
         s2_v      <= s1_v;
         rsp_valid <= s2_v;
      end
   end

   always_ff @(posedge clk) begin
      if (adv) begin
         s1_sum     <= sum;
         s1_unit_lo <= unit[OFF_W-1:0];
         s2_bank    <= residue;
         s2_diff    <= s1_unit_lo - OFF_W'(residue);
         rsp_bank   <= s2_bank;
         rsp_offset <= quotient;
      end
   end

endmodule

// File: rtl/pbm_checker.sv
module pbm_checker #(
   parameter int BANK_W  = 5,
   parameter int OFF_W   = 33,
   parameter int MODULUS = 31,
   parameter int DEPTH   = 3,
   localparam int CNT_W  = $clog2(DEPTH + 2)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic              rsp_valid,
   input logic              rsp_ready,
   input logic [BANK_W-1:0] rsp_bank,
   input logic [OFF_W-1:0]  rsp_offset
);

   logic [CNT_W-1:0] inflight;
   logic             in_fire, out_fire;

   assign in_fire  = req_valid && req_ready;
   assign out_fire = rsp_valid && rsp_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) inflight <= '0;
      else        inflight <= inflight + CNT_W'(in_fire) - CNT_W'(out_fire);
   end

   a_r1_bank_range: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (rsp_bank < BANK_W'(MODULUS)));

   a_r5_latency: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(in_fire, 3) && $past(rsp_ready, 2) && $past(rsp_ready, 1)) |-> rsp_valid);

   a_r6_depth: assert property (@(posedge clk) disable iff (!rst_n)
      inflight <= CNT_W'(DEPTH));

   a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_bank) && $stable(rsp_offset)));

   a_r8_stall_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_ready) |-> !req_ready);

   a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (inflight != '0));

endmodule

bind prime_bank_map pbm_checker #(
   .BANK_W(CHUNK_W), .OFF_W(OFF_W), .MODULUS(MODULUS), .DEPTH(3)
) u_pbm_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
   .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
   .rsp_bank(rsp_bank), .rsp_offset(rsp_offset)
);

// File: tb/prime_bank_map_tb.sv
module prime_bank_map_tb;

   localparam int ADDR_W = 40;
   localparam int BANK_W = 5;
   localparam int OFF_W  = 33;
   localparam int NB     = 31;

   logic              clk = 1'b0;
   logic              rst_n;
   logic              req_valid;
   logic              req_ready;
   logic [ADDR_W-1:0] req_addr;
   logic              req_line;
   logic              rsp_valid;
   logic              rsp_ready;
   logic [BANK_W-1:0] rsp_bank;
   logic [OFF_W-1:0]  rsp_offset;

   always #5 clk = ~clk;

   prime_bank_map u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_line(req_line), .rsp_valid(rsp_valid),
      .rsp_ready(rsp_ready), .rsp_bank(rsp_bank), .rsp_offset(rsp_offset)
   );

   typedef struct {
      int      bank;
      longint  off;
      string   tag;
   } exp_t;

   exp_t q[$];
   int   obs[$];
   int   checks = 0;
   int   errors = 0;
   int   rdy_mode = 0;   // 0: always ready, 1: random, 2: held low
   bit   done = 0;

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   // consumer ready, changed just after each rising edge
   initial begin
      rsp_ready = 1'b1;
      forever begin
         @(posedge clk);
         #2;
         case (rdy_mode)
            0:       rsp_ready = 1'b1;
            1:       rsp_ready = ($urandom % 3) != 0;
            default: rsp_ready = 1'b0;
         endcase
      end
   end

   // driver: present, wait for acceptance, push the expected result
   task automatic send(input logic [ADDR_W-1:0] a, input bit line);
      longint unsigned u;
      exp_t e;
      @(negedge clk);
      req_valid = 1'b1;
      req_addr  = a;
      req_line  = line;
      while (!req_ready) @(negedge clk);
      u = line ? (64'(a) >> 6) : (64'(a) >> 3);
      e.bank = int'(u % NB);
      e.off  = longint'(u / NB);
      if (e.bank == 0)  e.tag = "R4";
      else if (line)    e.tag = "R2";
      else              e.tag = "R1";
      q.push_back(e);
      @(posedge clk);
      #1 req_valid = 1'b0;
   endtask

   // monitor: every transfer is compared with the head of the queue (R6)
   always @(negedge clk) begin
      if (rst_n === 1'b1 && rsp_valid && rsp_ready) begin
         if (q.size() == 0) begin
            check(0, "R6", "response with empty scoreboard", 1, 0);
         end else begin
            exp_t e;
            e = q.pop_front();
            check(int'(rsp_bank) == e.bank, e.tag, "bank", rsp_bank, e.bank);
            check(longint'(rsp_offset) == e.off, "R3", "offset", rsp_offset, e.off);
            obs.push_back(int'(rsp_bank));
         end
      end
   end

   task automatic drain();
      while (q.size() != 0) @(negedge clk);
      repeat (2) @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL R6 watchdog: actual %0d expected %0d", q.size(), 0);
         finish_run();
      end
   end

   initial begin
      rst_n     = 1'b0;
      req_valid = 1'b0;
      req_addr  = '0;
      req_line  = 1'b0;
      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R9: idle after reset
      check(rsp_valid == 1'b0, "R9", "rsp_valid after reset", rsp_valid, 0);
      check(req_ready == 1'b1, "R9", "req_ready after reset", req_ready, 1);

      // R5: latency of three edges with the consumer ready
      send(40'(31 * 8), 1'b0);
      @(negedge clk);
      check(rsp_valid == 1'b0, "R5", "valid after 1 edge", rsp_valid, 0);
      @(negedge clk);
      check(rsp_valid == 1'b0, "R5", "valid after 2 edges", rsp_valid, 0);
      @(negedge clk);
      check(rsp_valid == 1'b1, "R5", "valid after 3 edges", rsp_valid, 1);
      drain();

      // R4 corners: slice sums folding to 31 or 32, zero, all ones
      send(40'd0, 1'b0);
      send(40'(62 * 8), 1'b0);
      send(40'(961 * 8), 1'b0);
      send(40'(31 * 64), 1'b1);
      send(40'(62 * 64 + 6'h3F), 1'b1);
      send(40'hFF_FFFF_FFFF, 1'b0);
      send(40'hFF_FFFF_FFFF, 1'b1);
      send(40'(32'd1023 * 8), 1'b0);   // sum 62 -> bank 0
      // R1/R2: byte bits below the unit are ignored
      send(40'(100 * 8 + 7), 1'b0);
      send(40'(100 * 64 + 63), 1'b1);
      drain();

      // R6: random mixed traffic under random backpressure
      rdy_mode = 1;
      for (int i = 0; i < 300; i++) begin
         send(ADDR_W'({$urandom, $urandom}), 1'($urandom));
      end
      drain();
      rdy_mode = 0;
      repeat (2) @(negedge clk);

      // R7/R8: hold the output stalled with a full pipeline
      rdy_mode = 2;
      @(negedge clk);
      send(40'(5 * 8), 1'b0);
      send(40'(6 * 8), 1'b0);
      send(40'(7 * 8), 1'b0);
      repeat (4) @(negedge clk);
      begin
         logic [BANK_W-1:0] b0;
         logic [OFF_W-1:0]  o0;
         b0 = rsp_bank;
         o0 = rsp_offset;
         check(rsp_valid == 1'b1, "R7", "valid during stall", rsp_valid, 1);
         for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check(rsp_valid == 1'b1, "R7", "valid held", rsp_valid, 1);
            check(rsp_bank == b0, "R7", "bank held", rsp_bank, b0);
            check(rsp_offset == o0, "R7", "offset held", rsp_offset, o0);
            check(req_ready == 1'b0, "R8", "req_ready while stalled", req_ready, 0);
         end
      end
      rdy_mode = 0;
      drain();
      check(req_ready == 1'b1, "R8", "req_ready when idle", req_ready, 1);

      // R10: stride sweep over 31-access windows
      for (int s = 1; s <= 64; s++) begin
         int h[NB];
         int hit, maxc;
         obs.delete();
         for (int k = 0; k < NB; k++) begin
            send(ADDR_W'((64'd17 + 64'(k) * 64'(s)) * 8), 1'b0);
         end
         drain();
         foreach (h[b]) h[b] = 0;
         foreach (obs[j]) h[obs[j]]++;
         hit = 0;
         maxc = 0;
         foreach (h[b]) begin
            if (h[b] != 0) hit++;
            if (h[b] > maxc) maxc = h[b];
         end
         if (s % NB == 0)
            check(hit == 1 && maxc == NB, "R10", $sformatf("banks hit, stride %0d", s), hit, 1);
         else
            check(hit == NB && maxc == 1, "R10", $sformatf("banks hit, stride %0d", s), hit, NB);
      end

      finish_run();
   end

endmodule